// File: doc/BRIEF.md
# Asynchronous Serial Character Receiver

This block turns a single asynchronous serial data line into parallel characters. A clock-enable tick at sixteen times the bit rate drives its timing. The block finds a start bit, confirms it at mid-bit, then samples each later bit at its centre. It assembles the data least significant bit first and checks the optional parity bit and the stop bit. It places each finished character in a one-entry holding register, where a consumer reads it.

Two run-time inputs select the format. One chooses 7 or 8 data bits. The other chooses no parity, even parity or odd parity. A flow-control output tells the far end whether it may keep sending. When the stop bit reads low, the receiver flags a framing error. It then treats that low level as the start bit of the next character. It does not wait for the line to return to idle.

Top module: `serial_char_rx`

## Requirements
- R1: After reset, `data_valid`, `hold_full`, `ovr_err`, `par_err` and `frm_err` are 0, `cts_out` is 1, and the receiver waits on an idle-high line.
- R2: A falling edge on the line starts a character only if the line is still 0 at the sample 8 ticks later. A low pulse shorter than that produces no character and leaves `hold_full` at 0.
- R3: Data bits are sampled 16 ticks apart and arrive least significant bit first. With `cfg_eight`=1 all 8 bits appear on `data_out`.
- R4: With `cfg_eight`=0, 7 data bits are received, and `data_out[7]` is 0.
- R5: `cfg_par` encodes 2'b00 none, 2'b01 even, 2'b10 odd, 2'b11 none. With parity on, one parity bit follows the data. `par_err` is 1 when the total count of ones in the data plus the parity bit is odd under even parity, or even under odd parity.
- R6: A stop-bit sample of 0 delivers the character with `frm_err`=1. A sample of 1 delivers it with `frm_err`=0.
- R7: After a framing error, the 0 sampled in the stop position acts as a confirmed start bit. The next data bit is sampled 16 ticks later, with no idle period in between.
- R8: Each accepted character raises `data_valid` for exactly one clock and sets `hold_full`. `hold_full` stays 1 until `rd_ack` is pulsed.
- R9: If a character completes while `hold_full` is 1 and `rd_ack` is not asserted, that character is dropped. `data_out` keeps the earlier byte, `ovr_err` becomes 1, and a pulse on `rd_ack` clears both `hold_full` and `ovr_err`.
- R10: `cts_out` is 1 exactly when the holding register is empty. It is 0 while `hold_full` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Clock enable at 16x the bit rate |
| rx_line | input | 1 | Serial data line, idles high |
| cfg_eight | input | 1 | 1: 8 data bits, 0: 7 data bits |
| cfg_par | input | 2 | Parity mode: 00 none, 01 even, 10 odd, 11 none |
| rd_ack | input | 1 | Consumer has taken the held character |
| data_out | output | 8 | Held character |
| data_valid | output | 1 | One-clock pulse when a new character is loaded |
| par_err | output | 1 | Parity error for the held character |
| frm_err | output | 1 | Framing error for the held character |
| ovr_err | output | 1 | A character was dropped while the register was full |
| hold_full | output | 1 | Holding register is occupied |
| cts_out | output | 1 | Flow control: 1 means the sender may transmit |

## Verification
The bench goes after the cases most likely to break. The first is a low glitch shorter than half a bit; a receiver without the mid-bit check would deliver a spurious 0xFF-like character. The second is a stop bit driven low with the next character's data following at once. A design that waits for idle would lose that character, and one that resamples the start bit would shift every bit by one. Seven-bit and parity cases catch a parity computed over the wrong number of bits and a stale bit 7. The overrun case holds the register full and checks that the old byte survives and that flow control stays low.

// File: rtl/srx_pkg.sv
package srx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_START = 3'd1,
    ST_DATA  = 3'd2,
    ST_PAR   = 3'd3,
    ST_STOP  = 3'd4
  } rx_state_t;

  localparam logic [1:0] PAR_NONE = 2'b00;
  localparam logic [1:0] PAR_EVEN = 2'b01;
  localparam logic [1:0] PAR_ODD  = 2'b10;
endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '1;
    else     chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/srx_framer.sv
module srx_framer
  import srx_pkg::*;
#(
  parameter int OSR = 16,
  parameter int DW  = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          rx,
  input  logic          cfg_eight,
  input  logic [1:0]    cfg_par,
  output logic          done_o,
  output logic [DW-1:0] byte_o,
  output logic          perr_o,
  output logic          ferr_o
);
  localparam int CW  = $clog2(OSR);
  localparam int BW  = $clog2(DW + 1);
  localparam logic [CW-1:0] MID  = CW'(OSR / 2 - 1);
  localparam logic [CW-1:0] LAST = CW'(OSR - 1);

  rx_state_t     state;
  logic [CW-1:0] cnt;
  logic [BW-1:0] bidx;
  logic [DW-1:0] sh;
  logic          pbit;
  logic          par_en;
  logic          par_odd;
  logic [BW-1:0] nbits;
  logic [DW-1:0] cur_byte;
  logic          at_sample;

  assign par_en    = (cfg_par == PAR_EVEN) || (cfg_par == PAR_ODD);
  assign par_odd   = (cfg_par == PAR_ODD);
  assign nbits     = cfg_eight ? BW'(DW) : BW'(DW - 1);
  assign cur_byte  = cfg_eight ? sh : {1'b0, sh[DW-1:1]};
  assign at_sample = (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      bidx   <= '0;
      sh     <= '0;
      pbit   <= 1'b0;
      done_o <= 1'b0;
      byte_o <= '0;
      perr_o <= 1'b0;
      ferr_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (tick) begin
        case (state)
          ST_IDLE: begin
            if (!rx) begin
              state <= ST_START;
              cnt   <= '0;
            end
          end
          ST_START: begin
            if (cnt == MID) begin
              cnt  <= '0;
              bidx <= '0;
              state <= rx ? ST_IDLE : ST_DATA;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_DATA: begin
            if (at_sample) begin
              cnt <= '0;
              sh  <= {rx, sh[DW-1:1]};
              if (bidx == nbits - 1'b1) state <= par_en ? ST_PAR : ST_STOP;
              else                      bidx  <= bidx + 1'b1;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_PAR: begin
            if (at_sample) begin
              cnt   <= '0;
              pbit  <= rx;
              state <= ST_STOP;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_STOP: begin
            if (at_sample) begin
              cnt    <= '0;
              bidx   <= '0;
              done_o <= 1'b1;
              byte_o <= cur_byte;
              perr_o <= par_en && ((^cur_byte) ^ pbit ^ par_odd);
              ferr_o <= !rx;
              state  <= rx ? ST_IDLE : ST_DATA;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  AST_SEVEN_TOP_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (done_o && !cfg_eight) |-> (byte_o[DW-1] == 1'b0)); // R4
  AST_FERR_RESYNC: assert property (@(posedge clk) disable iff (rst)
    (done_o && ferr_o) |-> (state == ST_DATA)); // R7
endmodule

// File: rtl/srx_hold.sv
module srx_hold #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          done,
  input  logic [DW-1:0] byte_in,
  input  logic          perr_in,
  input  logic          ferr_in,
  input  logic          rd_ack,
  output logic [DW-1:0] data_out,
  output logic          data_valid,
  output logic          par_err,
  output logic          frm_err,
  output logic          ovr_err,
  output logic          hold_full,
  output logic          cts_out
);
  logic full_after_rd;
  logic ovr_after_rd;
  logic load;

  assign full_after_rd = hold_full && !rd_ack;
  assign ovr_after_rd  = ovr_err && !rd_ack;
  assign load          = done && !full_after_rd;

  always_ff @(posedge clk) begin
    if (rst) begin
      data_out   <= '0;
      data_valid <= 1'b0;
      par_err    <= 1'b0;
      frm_err    <= 1'b0;
      ovr_err    <= 1'b0;
      hold_full  <= 1'b0;
      cts_out    <= 1'b1;
    end else begin
      data_valid <= load;
      if (load) begin
        data_out <= byte_in;
        par_err  <= perr_in;
        frm_err  <= ferr_in;
      end
      hold_full <= full_after_rd || load;
      cts_out   <= !(full_after_rd || load);
      ovr_err   <= ovr_after_rd || (done && full_after_rd);
    end
  end

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
    data_valid |=> !data_valid); // R8
  AST_VALID_SETS_FULL: assert property (@(posedge clk) disable iff (rst)
    data_valid |-> hold_full); // R8
  AST_CTS_WHEN_FULL: assert property (@(posedge clk) disable iff (rst)
    hold_full |-> !cts_out); // R10
  AST_OVR_KEEPS_BYTE: assert property (@(posedge clk) disable iff (rst)
    (done && hold_full && !rd_ack) |=> ($stable(data_out) && ovr_err)); // R9
endmodule

// File: rtl/serial_char_rx.sv
module serial_char_rx #(
  parameter int OSR         = 16,
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          rx_line,
  input  logic          cfg_eight,
  input  logic [1:0]    cfg_par,
  input  logic          rd_ack,
  output logic [DW-1:0] data_out,
  output logic          data_valid,
  output logic          par_err,
  output logic          frm_err,
  output logic          ovr_err,
  output logic          hold_full,
  output logic          cts_out
);
  logic          rx_s;
  logic          f_done;
  logic [DW-1:0] f_byte;
  logic          f_perr;
  logic          f_ferr;

  srx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .din (rx_line),
    .dout(rx_s)
  );

  srx_framer #(.OSR(OSR), .DW(DW)) u_framer (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .rx       (rx_s),
    .cfg_eight(cfg_eight),
    .cfg_par  (cfg_par),
    .done_o   (f_done),
    .byte_o   (f_byte),
    .perr_o   (f_perr),
    .ferr_o   (f_ferr)
  );

  srx_hold #(.DW(DW)) u_hold (
    .clk       (clk),
    .rst       (rst),
    .done      (f_done),
    .byte_in   (f_byte),
    .perr_in   (f_perr),
    .ferr_in   (f_ferr),
    .rd_ack    (rd_ack),
    .data_out  (data_out),
    .data_valid(data_valid),
    .par_err   (par_err),
    .frm_err   (frm_err),
    .ovr_err   (ovr_err),
    .hold_full (hold_full),
    .cts_out   (cts_out)
  );
endmodule

// File: tb/serial_char_rx_test.sv
module serial_char_rx_test;
  localparam int TDIV = 4;
  localparam int BIT  = 16 * TDIV;

  typedef struct {
    logic [7:0] d;
    logic       pe;
    logic       fe;
    string      tag;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic       rx_line = 1'b1;
  logic       cfg_eight = 1'b1;
  logic [1:0] cfg_par = 2'b00;
  logic       mon_ack = 1'b0;
  logic       man_ack = 1'b0;
  logic       rd_ack;
  logic [7:0] data_out;
  logic       data_valid, par_err, frm_err, ovr_err, hold_full, cts_out;

  int   n_chk = 0;
  int   n_bad = 0;
  bit   auto_rd = 1'b1;
  int   cyc = 0;
  int   tdc = 0;
  exp_t q[$];

  assign rd_ack = mon_ack | man_ack;

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    tdc <= (tdc == TDIV - 1) ? 0 : tdc + 1;
    tick <= (tdc == TDIV - 1);
  end

  serial_char_rx uut (
    .clk(clk), .rst(rst), .tick(tick), .rx_line(rx_line),
    .cfg_eight(cfg_eight), .cfg_par(cfg_par), .rd_ack(rd_ack),
    .data_out(data_out), .data_valid(data_valid), .par_err(par_err),
    .frm_err(frm_err), .ovr_err(ovr_err), .hold_full(hold_full),
    .cts_out(cts_out)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Monitor: pop expected characters as the design produces them.
  always @(negedge clk) begin
    mon_ack <= 1'b0;
    if (!rst && data_valid) begin
      if (q.size() == 0) begin
        check(1'b0, "R2 unexpected character", data_out, 0);
      end else begin
        exp_t e;
        e = q.pop_front();
        check(data_out == e.d && par_err == e.pe && frm_err == e.fe, e.tag,
              {data_out, 3'b0, par_err, 3'b0, frm_err}, {e.d, 3'b0, e.pe, 3'b0, e.fe});
      end
      if (auto_rd) mon_ack <= 1'b1;
    end
  end

  task automatic bit_time();
    repeat (BIT) @(negedge clk);
  endtask

  task automatic idle(input int n);
    rx_line = 1'b1;
    repeat (n) bit_time();
  endtask

  task automatic send_char(input logic [7:0] d, input bit eight, input logic [1:0] par,
                           input bit bad_par, input bit stop_v, input bit with_start,
                           input bit expect_it, input string tag);
    logic [7:0] ed;
    bit pen;
    logic pb;
    exp_t e;
    cfg_eight = eight;
    cfg_par   = par;
    ed  = eight ? d : {1'b0, d[6:0]};
    pen = (par == 2'b01) || (par == 2'b10);
    pb  = (^ed) ^ (par == 2'b10) ^ bad_par;
    if (expect_it) begin
      e.d = ed; e.pe = pen && bad_par; e.fe = !stop_v; e.tag = tag;
      q.push_back(e);
    end
    if (with_start) begin rx_line = 1'b0; bit_time(); end
    for (int i = 0; i < (eight ? 8 : 7); i++) begin rx_line = ed[i]; bit_time(); end
    if (pen) begin rx_line = pb; bit_time(); end
    rx_line = stop_v;
    bit_time();
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check(!hold_full && !data_valid && !ovr_err, "R1 flags after reset", {hold_full, ovr_err}, 0);
    check(cts_out === 1'b1, "R1 cts after reset", cts_out, 1);
    check(!par_err && !frm_err, "R1 error flags after reset", {par_err, frm_err}, 0);
    idle(2);

    // R3: 8-bit data, no parity, several patterns
    send_char(8'hA5, 1, 2'b00, 0, 1, 1, 1, "R3 8bit A5");
    idle(1);
    send_char(8'h01, 1, 2'b00, 0, 1, 1, 1, "R3 8bit 01 lsb first");
    idle(1);
    send_char(8'h80, 1, 2'b11, 0, 1, 1, 1, "R3 R5 8bit 80 mode 11 none");
    idle(1);

    // R4: 7-bit characters, bit 7 dropped
    send_char(8'hFF, 0, 2'b00, 0, 1, 1, 1, "R4 7bit FF");
    idle(1);
    send_char(8'h65, 0, 2'b00, 0, 1, 1, 1, "R4 7bit 65");
    idle(1);

    // R5: parity modes good and bad
    send_char(8'h37, 1, 2'b01, 0, 1, 1, 1, "R5 even good");
    idle(1);
    send_char(8'h37, 1, 2'b01, 1, 1, 1, 1, "R5 even bad");
    idle(1);
    send_char(8'h5A, 1, 2'b10, 0, 1, 1, 1, "R5 odd good");
    idle(1);
    send_char(8'h5A, 1, 2'b10, 1, 1, 1, 1, "R5 odd bad");
    idle(1);
    send_char(8'h41, 0, 2'b01, 1, 1, 1, 1, "R5 R4 7bit even bad");
    idle(1);
    send_char(8'h41, 0, 2'b10, 0, 1, 1, 1, "R5 R4 7bit odd good");
    idle(1);

    // R6, R7: framing error, then data follows directly
    send_char(8'h3C, 1, 2'b00, 0, 0, 1, 1, "R6 stop low");
    send_char(8'hC3, 1, 2'b00, 0, 1, 0, 1, "R7 resync char");
    idle(1);
    send_char(8'h0F, 1, 2'b01, 0, 0, 1, 1, "R6 stop low with parity");
    send_char(8'h96, 1, 2'b01, 0, 1, 0, 1, "R7 resync with parity");
    idle(2);

    // R2: short low glitch (3 ticks)
    rx_line = 1'b0;
    repeat (3 * TDIV) @(negedge clk);
    rx_line = 1'b1;
    idle(2);
    check(!hold_full, "R2 glitch ignored", hold_full, 0);
    send_char(8'h22, 1, 2'b00, 0, 1, 1, 1, "R2 char after glitch");
    idle(1);

    // R8, R9, R10: overrun with consumer stalled
    auto_rd = 1'b0;
    send_char(8'h11, 1, 2'b00, 0, 1, 1, 1, "R8 first held");
    idle(1);
    check(hold_full === 1'b1, "R8 full held", hold_full, 1);
    check(cts_out === 1'b0, "R10 cts low while full", cts_out, 0);
    send_char(8'h99, 1, 2'b00, 0, 1, 1, 0, "R9 dropped");
    idle(1);
    check(ovr_err === 1'b1, "R9 overrun flag", ovr_err, 1);
    check(data_out == 8'h11, "R9 old byte kept", data_out, 8'h11);
    man_ack = 1'b1;
    @(negedge clk);
    man_ack = 1'b0;
    @(negedge clk);
    check(!hold_full && !ovr_err, "R9 read clears", {hold_full, ovr_err}, 0);
    check(cts_out === 1'b1, "R10 cts high when empty", cts_out, 1);
    auto_rd = 1'b1;
    send_char(8'h7E, 1, 2'b00, 0, 1, 1, 1, "R8 after clear");
    idle(2);

    check(q.size() == 0, "R8 all characters delivered", q.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  always @(negedge clk) begin
    if (cyc > 150000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule